// File: doc/BRIEF.md
# Multiphase Twisted-Ring Clock Divider

This block divides its input clock by an even ratio 2·STAGES. It uses a ring of STAGES flip-flops that all shift on the same clock edge. The first stage loads the inverse of the last stage. Each stage output is a square wave at the divided rate, and each stage lags the stage before it by one input cycle, which is 360/(2·STAGES) degrees of the output period. All stage outputs are available on a phase bus, and one of them, chosen by the parameter PRIMARY_TAP, also drives a single primary divided output.

The block is controlled by a small step selector. It chooses one of four named steps on every edge:
- **STEP_CLEAR**: synchronous reset asserted. The ring loads all zeros.
- **STEP_HOLD**: enable low. The ring keeps its value.
- **STEP_SHIFT**: enabled and the ring pattern is legal. The ring advances one position.
- **STEP_FLUSH**: enabled and the ring pattern is illegal. The ring loads all zeros.

The transitions are:
- Reset wins over everything else.
- With reset low, enable low always selects HOLD.
- With reset low and enable high, the legality detector chooses between SHIFT and FLUSH.

A pattern is legal when adjacent stages disagree in at most one place. This covers exactly the 2·STAGES members of the normal cycle. Any other pattern, for example one produced by an upset, returns to the cycle through the all-zeros state on the next enabled edge.

Top module: `phase_ring_divider`

## Requirements
- R1: When rst_i is high at a clock edge, every bit of phase_o is 0 after that edge. Reset takes priority over a low enable and over an illegal pattern.
- R2: With en_i high and a legal pattern, each edge moves stage i-1 into stage i. Stage 0 takes the inverse of stage STAGES-1.
- R3: With STAGES=3, starting from reset, the sequence is 000, 100, 110, 111, 011, 001, then it repeats. Each pattern is written with stage 0 leftmost, and bit n of phase_o is stage n.
- R4: With en_i low and rst_i low, phase_o does not change across clock edges.
- R5: Once the ring is in its legal cycle, every stage output repeats every 2·STAGES enabled edges and is high for exactly STAGES of them.
- R6: Stage i rises exactly i enabled edges after stage 0 rises, so neighbouring stages are 360/(2·STAGES) degrees apart.
- R7: A pattern in which more than one pair of neighbouring stages differ, seen with en_i high, becomes all zeros after the next edge. This is well within STAGES edges.
- R8: div_o always equals phase_o[PRIMARY_TAP].
- R9: Each added stage raises the ratio by two: STAGES=4 divides by 8 and passes through 8 distinct legal patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high; clears the ring |
| en_i | input | 1 | Advance enable; low freezes the ring |
| phase_o | output | STAGES | All stage outputs, bit n = stage n |
| div_o | output | 1 | Primary divided clock, stage PRIMARY_TAP |

## Verification
Reset and repair can both apply to the same edge, when an illegal pattern is present while rst_i is high. Reset can also coincide with a hold request. The bench forces the ring of each instance into an illegal pattern, or stops it mid-cycle with en_i low, and then raises rst_i for that edge. Reset must win in both cases and leave all zeros. Separately, it forces illegal patterns with reset low and checks that the flush alone lands on all zeros within one edge.

// File: rtl/ring_pkg.sv
package ring_pkg;

    // Per-edge action chosen for the ring register
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_SHIFT = 2'd1,
        STEP_FLUSH = 2'd2,
        STEP_CLEAR = 2'd3
    } ring_step_e;

endpackage

// File: rtl/ring_legal_check.sv
module ring_legal_check #(
    parameter int STAGES = 3
) (
    input  logic [STAGES-1:0] ring_i,
    output logic              legal_o
);
    localparam int CW = $clog2(STAGES) + 1;

    logic [CW-1:0] flips;

    // Count neighbour disagreements; a legal ring has at most one
    always_comb begin
        flips = '0;
        for (int i = 1; i < STAGES; i++) begin
            flips = flips + CW'(ring_i[i] ^ ring_i[i-1]);
        end
        legal_o = (flips <= CW'(1));
    end

endmodule

// File: rtl/ring_step_sel.sv
module ring_step_sel
    import ring_pkg::*;
(
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       legal_i,
    output ring_step_e step_o
);

    always_comb begin
        step_o = STEP_HOLD;
        unique casez ({rst_i, en_i, legal_i})
            3'b1??:  step_o = STEP_CLEAR;
            3'b00?:  step_o = STEP_HOLD;
            3'b010:  step_o = STEP_FLUSH;
            3'b011:  step_o = STEP_SHIFT;
            default: step_o = STEP_HOLD;
        endcase
    end

endmodule

// File: rtl/ring_shift_reg.sv
module ring_shift_reg
    import ring_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk_i,
    input  ring_step_e        step_i,
    output logic [STAGES-1:0] state_q
);

    // State register: the only storage in the divider
    always_ff @(posedge clk_i) begin
        unique case (step_i)
            STEP_CLEAR: state_q <= '0;
            STEP_FLUSH: state_q <= '0;
            STEP_SHIFT: state_q <= {state_q[STAGES-2:0], ~state_q[STAGES-1]};
            STEP_HOLD:  state_q <= state_q;
            default:    state_q <= state_q;
        endcase
    end

endmodule

// File: rtl/phase_ring_divider.sv
module phase_ring_divider
    import ring_pkg::*;
#(
    parameter int STAGES      = 3,
    parameter int PRIMARY_TAP = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    output logic [STAGES-1:0] phase_o,
    output logic              div_o
);
    localparam int RATIO = 2 * STAGES;
    localparam int TAP   = (PRIMARY_TAP < STAGES) ? PRIMARY_TAP : STAGES - 1;

    ring_step_e        step;
    logic              ring_ok;
    logic [STAGES-1:0] ring_q;

    ring_legal_check #(.STAGES(STAGES)) u_legal (
        .ring_i  (ring_q),
        .legal_o (ring_ok)
    );

    ring_step_sel u_sel (
        .rst_i   (rst_i),
        .en_i    (en_i),
        .legal_i (ring_ok),
        .step_o  (step)
    );

    ring_shift_reg #(.STAGES(STAGES)) u_ring (
        .clk_i   (clk_i),
        .step_i  (step),
        .state_q (ring_q)
    );

    // Output process: one phase tap per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_tap
        assign phase_o[g] = ring_q[g];
    end

    assign div_o = ring_q[TAP];

    // R1
    reset_zero_chk: assert property (@(posedge clk_i)
        rst_i |=> (phase_o == '0));

    // R4
    hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(phase_o));

    // R2
    feedback_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && ring_ok) |=> (!ring_ok || (phase_o[0] != $past(phase_o[STAGES-1]))));

    // R6
    lag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && ring_ok) |=> (!ring_ok || (phase_o[STAGES-1:1] == $past(phase_o[STAGES-2:0]))));

    // R7
    repair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !ring_ok) |=> (phase_o == '0));

    initial begin
        if (RATIO < 4) $error("phase_ring_divider needs at least two stages");
    end

endmodule

// File: tb/phase_ring_divider_test.sv
module phase_ring_divider_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [2:0] ph3;
    logic       dv3;
    logic [3:0] ph4;
    logic       dv4;
    int         n_chk  = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    phase_ring_divider #(.STAGES(3), .PRIMARY_TAP(0)) uut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .phase_o(ph3), .div_o(dv3));

    phase_ring_divider #(.STAGES(4), .PRIMARY_TAP(2)) uut_k4 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .phase_o(ph4), .div_o(dv4));

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 k3 reset", int'(ph3), 0);
        check("R1 k4 reset", int'(ph4), 0);
    endtask

    // R3: stage0-leftmost 000,100,110,111,011,001 as phase_o values
    task automatic t_seq3();
        int tbl [6] = '{0, 1, 3, 7, 6, 4};
        do_reset();
        en = 1'b1;
        for (int n = 1; n <= 12; n++) begin
            tick();
            check("R3 k3 sequence", int'(ph3), tbl[n % 6]);
        end
    endtask

    // R9 and R2: eight distinct patterns, next = shift in inverse of last
    task automatic t_seq4();
        logic [3:0] exp4 = '0;
        logic [15:0] seen = '0;
        do_reset();
        en = 1'b1;
        for (int n = 1; n <= 16; n++) begin
            exp4 = {exp4[2:0], ~exp4[3]};
            tick();
            check("R2 k4 shift", int'(ph4), int'(exp4));
            seen[ph4] = 1'b1;
        end
        check("R9 k4 distinct states", $countones(seen), 8);
    endtask

    // R5 and R6: periods, duty and phase lag of every stage
    task automatic t_timing();
        int r3a [3];
        int r3b [3];
        int h3  [3];
        int r4a [4];
        int r4b [4];
        int h4  [4];
        logic [2:0] p3;
        logic [3:0] p4;
        for (int i = 0; i < 3; i++) begin r3a[i] = -1; r3b[i] = -1; h3[i] = 0; end
        for (int i = 0; i < 4; i++) begin r4a[i] = -1; r4b[i] = -1; h4[i] = 0; end
        do_reset();
        en = 1'b1;
        p3 = ph3;
        p4 = ph4;
        for (int n = 1; n <= 30; n++) begin
            tick();
            for (int i = 0; i < 3; i++) begin
                if (ph3[i] && !p3[i]) begin
                    if (r3a[i] < 0) r3a[i] = n; else if (r3b[i] < 0) r3b[i] = n;
                end
                if (r3a[i] >= 0 && r3b[i] < 0 && ph3[i]) h3[i]++;
            end
            for (int i = 0; i < 4; i++) begin
                if (ph4[i] && !p4[i]) begin
                    if (r4a[i] < 0) r4a[i] = n; else if (r4b[i] < 0) r4b[i] = n;
                end
                if (r4a[i] >= 0 && r4b[i] < 0 && ph4[i]) h4[i]++;
            end
            p3 = ph3;
            p4 = ph4;
        end
        for (int i = 0; i < 3; i++) begin
            check("R5 k3 period", r3b[i] - r3a[i], 6);
            check("R5 k3 high", h3[i], 3);
            check("R6 k3 lag", r3a[i] - r3a[0], i);
        end
        for (int i = 0; i < 4; i++) begin
            check("R5 k4 period", r4b[i] - r4a[i], 8);
            check("R5 k4 high", h4[i], 4);
            check("R6 k4 lag", r4a[i] - r4a[0], i);
        end
    endtask

    task automatic t_primary();
        do_reset();
        en = 1'b1;
        for (int n = 0; n < 9; n++) begin
            tick();
            check("R8 k3 primary", int'(dv3), int'(ph3[0]));
            check("R8 k4 primary", int'(dv4), int'(ph4[2]));
        end
    endtask

    task automatic t_hold();
        logic [2:0] s3;
        logic [3:0] s4;
        do_reset();
        en = 1'b1;
        tick();
        tick();
        en = 1'b0;
        s3 = ph3;
        s4 = ph4;
        for (int n = 0; n < 4; n++) begin
            tick();
            check("R4 k3 hold", int'(ph3), int'(s3));
            check("R4 k4 hold", int'(ph4), int'(s4));
        end
        en = 1'b1;
        tick();
        check("R4 k3 resume", int'(ph3), 7);
        check("R4 k4 resume", int'(ph4), 7);
    endtask

    task automatic inject(input logic [2:0] v3, input logic [3:0] v4);
        force uut.u_ring.state_q = v3;
        force uut_k4.u_ring.state_q = v4;
        #2;
        release uut.u_ring.state_q;
        release uut_k4.u_ring.state_q;
        #1;
    endtask

    // R7: illegal patterns flush to zero in one enabled edge
    task automatic t_repair();
        do_reset();
        en = 1'b1;
        tick();
        inject(3'b010, 4'b1001);
        check("R7 k3 injected", int'(ph3), 2);
        tick();
        check("R7 k3 flush 010", int'(ph3), 0);
        check("R7 k4 flush 1001", int'(ph4), 0);
        tick();
        check("R7 k3 rejoins", int'(ph3), 1);
        inject(3'b101, 4'b0110);
        tick();
        check("R7 k3 flush 101", int'(ph3), 0);
        check("R7 k4 flush 0110", int'(ph4), 0);
    endtask

    // R1 priority over hold and over repair
    task automatic t_collide();
        do_reset();
        en = 1'b1;
        tick();
        tick();
        en  = 1'b0;
        rst = 1'b1;
        tick();
        check("R1 k3 reset beats hold", int'(ph3), 0);
        check("R1 k4 reset beats hold", int'(ph4), 0);
        rst = 1'b0;
        en  = 1'b1;
        tick();
        rst = 1'b1;
        inject(3'b101, 4'b1010);
        tick();
        check("R1 k3 reset with illegal", int'(ph3), 0);
        check("R1 k4 reset with illegal", int'(ph4), 0);
        rst = 1'b0;
        tick();
        check("R1 k3 after reset", int'(ph3), 1);
    endtask

    initial begin
        fork
            begin
                tick();
                t_reset();
                t_seq3();
                t_seq4();
                t_timing();
                t_primary();
                t_hold();
                t_repair();
                t_collide();
            end
            begin
                #4000000;
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule